// File: doc/BRIEF.md
# Banked Internal Data-Memory Controller

This block serves the internal data space of a small 8-bit processor core. Each request carries an 8-bit address, an access mode and the two register-bank select bits. The control half decodes the request and picks one target: a 256-byte scratch RAM, a separate 256-byte expanded RAM, or an outward port toward the special-function registers. The datapath half then performs the read or write on that target.

The scratch RAM is split by address and mode. Its low half can be reached with either direct or indirect addressing. Its high half can be reached only indirectly, because a direct access to the same high addresses leaves on the SFR port. Register accesses fold a 3-bit register number and the bank select into the bottom 32 bytes. Single-bit accesses are mapped onto a 16-byte window starting at 20h, and the block updates one bit of the byte there while keeping the other seven. Bit addresses with the top bit set are forwarded on the SFR port so that an external SFR can handle them.

Every request returns its read data one cycle later with a valid flag. A request that is not allowed (an expanded access while the expanded RAM is off, or an undefined mode code) raises a decode-error flag in that same result cycle and changes no storage.

Top module: `banked_dmem`

## Requirements
- R1: While reset is held, and in the first cycle after reset, rdData is 00h and rdValid, decodeErr and sfrReq are 0. All 512 storage bytes read back as 00h after reset.
- R2: In direct mode (accMode 0) or indirect mode (accMode 1), addresses 00h-7Fh reach the same scratch RAM bytes.
- R3: In indirect mode, addresses 80h-FFh reach the upper scratch RAM bytes. sfrReq stays 0.
- R4: In direct mode, addresses 80h-FFh go to the SFR port and never to RAM. In the request cycle, sfrReq=1, sfrAddr=addr, sfrWr=wrEn and sfrWrData=wrData. One cycle later, rdData equals the sfrRdData that was present in the request cycle.
- R5: In register mode (accMode 2), the byte address is {000b, bankSel[1:0], addr[2:0]}, so banks 0 to 3 start at 00h, 08h, 10h and 18h. addr[7:3] is ignored.
- R6: In bit mode (accMode 3), a bit address b below 80h selects bit b[2:0] of byte 20h+b[6:3]. A read returns that bit in rdData[0], with rdData[7:1]=0. A write stores wrData[0] into that bit and leaves the other seven bits unchanged.
- R7: In bit mode, a bit address from 80h to FFh goes to the SFR port with sfrBitOp=1, sfrAddr equal to the bit address, and sfrWrData={0000000b, wrData[0]} on a write. The result is sfrRdData[0] in rdData[0].
- R8: Expanded mode (accMode 4) with xramEnable=1 reaches a separate 256-byte RAM at 00h-FFh. This RAM does not overlap the scratch RAM.
- R9: Every request with reqValid=1 is answered exactly one cycle later with rdValid=1. A write returns the data that was stored before the write.
- R10: An expanded access with xramEnable=0, or any accMode of 5 to 7, sets decodeErr=1 and rdData=00h one cycle later. No storage changes and the SFR port is not touched.
- R11: With reqValid=0, no storage changes and sfrReq and sfrWr stay 0, whatever wrEn holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| accMode | input | 3 | 0 direct, 1 indirect, 2 register, 3 bit, 4 expanded |
| addr | input | 8 | Byte address, register number or bit address |
| bankSel | input | 2 | Register bank select |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data; bit 0 only for bit mode |
| xramEnable | input | 1 | Expanded RAM accessible |
| sfrRdData | input | 8 | Read data from the SFR side |
| sfrReq | output | 1 | SFR access this cycle |
| sfrWr | output | 1 | SFR write this cycle |
| sfrBitOp | output | 1 | SFR access is a single-bit access |
| sfrAddr | output | 8 | SFR byte or bit address |
| sfrWrData | output | 8 | SFR write data |
| rdData | output | 8 | Read result, one cycle after the request |
| rdValid | output | 1 | rdData holds a result |
| decodeErr | output | 1 | The request was refused |

## Verification
The same addresses are tried under several modes. A byte is written directly and read back indirectly. An upper address is written indirectly and then reached directly, which must reach the SFR side and leave the RAM byte intact. A register write into a non-zero bank is read back directly, and the same register in bank 0 is read to show that the bank bits take effect. Bit writes of both polarities into a byte with a known pattern show that the other seven bits survive. Expanded accesses at an address already used in scratch RAM show that the two spaces do not overlap. Refused requests show that neither RAM changes.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;
  localparam int BANK_SEL_W  = 2;
  localparam int REG_IDX_W   = 3;
  localparam int BIT_IDX_W   = 3;
  localparam int MODE_W      = 3;
  localparam int RAM_DEPTH   = 1 << ADDR_W;
  localparam int STORE_COUNT = 2;          // 0 scratch RAM, 1 expanded RAM
  localparam logic [ADDR_W-1:0] BIT_AREA_BASE = 8'h20;

  localparam logic [MODE_W-1:0] MODE_DIRECT   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_INDIRECT = 3'd1;
  localparam logic [MODE_W-1:0] MODE_REGISTER = 3'd2;
  localparam logic [MODE_W-1:0] MODE_BIT      = 3'd3;
  localparam logic [MODE_W-1:0] MODE_EXPANDED = 3'd4;

  typedef struct packed {
    logic                 active;
    logic                 iramSel;
    logic                 xramSel;
    logic                 sfrSel;
    logic                 bitOp;
    logic                 wrReq;
    logic                 err;
    logic [ADDR_W-1:0]    byteAddr;
    logic [BIT_IDX_W-1:0] bitPos;
  } dmemStrobes_t;

endpackage

// File: rtl/dmem_store.sv
module dmem_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdByte
);

  logic [DW-1:0] cells [DEPTH];

  // The read is combinational so that a bit write can merge into the old byte in one cycle.
  assign rdByte = cells[addr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (wrEn) begin
      cells[addr] <= wrData;
    end
  end

endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
(
  input  logic                  reqValid,
  input  logic [MODE_W-1:0]     accMode,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BANK_SEL_W-1:0] bankSel,
  input  logic                  wrEn,
  input  logic                  xramEnable,
  output dmemStrobes_t          strobes
);

  localparam int BIT_BYTE_W = ADDR_W - 1 - BIT_IDX_W;

  logic                  upperHalf;
  logic [ADDR_W-1:0]     regByte;
  logic [ADDR_W-1:0]     bitByte;
  logic [BIT_BYTE_W-1:0] bitByteOfs;

  assign upperHalf  = addr[ADDR_W-1];
  assign regByte    = ADDR_W'({bankSel, addr[REG_IDX_W-1:0]});
  assign bitByteOfs = addr[ADDR_W-2:BIT_IDX_W];
  assign bitByte    = BIT_AREA_BASE + ADDR_W'(bitByteOfs);

  always_comb begin
    strobes = '0;
    if (reqValid) begin
      strobes.active = 1'b1;
      strobes.wrReq  = wrEn;
      case (accMode)
        MODE_DIRECT: begin
          strobes.byteAddr = addr;
          if (upperHalf) strobes.sfrSel  = 1'b1;
          else           strobes.iramSel = 1'b1;
        end
        MODE_INDIRECT: begin
          strobes.byteAddr = addr;
          strobes.iramSel  = 1'b1;
        end
        MODE_REGISTER: begin
          strobes.byteAddr = regByte;
          strobes.iramSel  = 1'b1;
        end
        MODE_BIT: begin
          strobes.bitOp  = 1'b1;
          strobes.bitPos = addr[BIT_IDX_W-1:0];
          if (upperHalf) begin
            strobes.sfrSel   = 1'b1;
            strobes.byteAddr = addr;
          end else begin
            strobes.iramSel  = 1'b1;
            strobes.byteAddr = bitByte;
          end
        end
        MODE_EXPANDED: begin
          strobes.byteAddr = addr;
          if (xramEnable) strobes.xramSel = 1'b1;
          else            strobes.err     = 1'b1;
        end
        default: strobes.err = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/dmem_datapath.sv
module dmem_datapath
  import dmem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dmemStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] sfrRdData,
  output logic              sfrReq,
  output logic              sfrWr,
  output logic              sfrBitOp,
  output logic [ADDR_W-1:0] sfrAddr,
  output logic [DATA_W-1:0] sfrWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              decodeErr
);

  logic [STORE_COUNT-1:0] storeWr;
  logic [DATA_W-1:0]      storeRd [STORE_COUNT];
  logic [DATA_W-1:0]      oldByte;
  logic [DATA_W-1:0]      newByte;
  logic [DATA_W-1:0]      nextRd;
  logic                   oldBit;

  assign storeWr[0] = strobes.iramSel & strobes.wrReq;
  assign storeWr[1] = strobes.xramSel & strobes.wrReq;

  for (genvar g = 0; g < STORE_COUNT; g++) begin : gStore
    dmem_store #(.DEPTH(RAM_DEPTH), .DW(DATA_W)) uStore (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (storeWr[g]),
      .addr   (strobes.byteAddr),
      .wrData (newByte),
      .rdByte (storeRd[g])
    );
  end

  assign oldByte = strobes.xramSel ? storeRd[1] : storeRd[0];
  assign oldBit  = oldByte[strobes.bitPos];

  always_comb begin
    newByte = wrData;
    if (strobes.bitOp) begin
      newByte = oldByte;
      newByte[strobes.bitPos] = wrData[0];
    end
  end

  assign sfrReq    = strobes.sfrSel;
  assign sfrWr     = strobes.sfrSel & strobes.wrReq;
  assign sfrBitOp  = strobes.sfrSel & strobes.bitOp;
  assign sfrAddr   = strobes.sfrSel ? strobes.byteAddr : '0;
  assign sfrWrData = !sfrWr ? '0 :
                     strobes.bitOp ? DATA_W'(wrData[0]) : wrData;

  always_comb begin
    nextRd = '0;
    if (strobes.active && !strobes.err) begin
      if (strobes.sfrSel)
        nextRd = strobes.bitOp ? DATA_W'(sfrRdData[0]) : sfrRdData;
      else
        nextRd = strobes.bitOp ? DATA_W'(oldBit) : oldByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      rdValid   <= 1'b0;
      decodeErr <= 1'b0;
    end else begin
      rdData    <= nextRd;
      rdValid   <= strobes.active;
      decodeErr <= strobes.err;
    end
  end

endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
  import dmem_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [MODE_W-1:0]     accMode,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BANK_SEL_W-1:0] bankSel,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  xramEnable,
  input  logic [DATA_W-1:0]     sfrRdData,
  output logic                  sfrReq,
  output logic                  sfrWr,
  output logic                  sfrBitOp,
  output logic [ADDR_W-1:0]     sfrAddr,
  output logic [DATA_W-1:0]     sfrWrData,
  output logic [DATA_W-1:0]     rdData,
  output logic                  rdValid,
  output logic                  decodeErr
);

  dmemStrobes_t strobes;

  dmem_ctrl uCtrl (
    .reqValid   (reqValid),
    .accMode    (accMode),
    .addr       (addr),
    .bankSel    (bankSel),
    .wrEn       (wrEn),
    .xramEnable (xramEnable),
    .strobes    (strobes)
  );

  dmem_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .sfrRdData (sfrRdData),
    .sfrReq    (sfrReq),
    .sfrWr     (sfrWr),
    .sfrBitOp  (sfrBitOp),
    .sfrAddr   (sfrAddr),
    .sfrWrData (sfrWrData),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .decodeErr (decodeErr)
  );

endmodule

// File: rtl/dmem_checker.sv
module dmem_checker
  import dmem_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [MODE_W-1:0] accMode,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              xramEnable,
  input logic              sfrReq,
  input logic              sfrWr,
  input logic              sfrBitOp,
  input logic [ADDR_W-1:0] sfrAddr,
  input logic [DATA_W-1:0] sfrWrData,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              decodeErr
);

  a_r4_direct_upper_to_sfr: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accMode == MODE_DIRECT && addr[ADDR_W-1])
      |-> (sfrReq && sfrAddr == addr && sfrWr == wrEn && (!wrEn || sfrWrData == wrData)));

  a_r3_indirect_never_sfr: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accMode == MODE_INDIRECT) |-> !sfrReq);

  a_r7_upper_bit_to_sfr: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accMode == MODE_BIT && addr[ADDR_W-1])
      |-> (sfrReq && sfrBitOp && sfrAddr == addr));

  a_r9_one_cycle_answer: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rdValid);

  a_r9_no_spurious_answer: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rdValid);

  a_r10_refused_expanded: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accMode == MODE_EXPANDED && !xramEnable)
      |-> (!sfrReq ##1 (decodeErr && rdData == '0)));

  a_r11_idle_port_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!sfrReq && !sfrWr));

endmodule

bind banked_dmem dmem_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .accMode    (accMode),
  .addr       (addr),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .xramEnable (xramEnable),
  .sfrReq     (sfrReq),
  .sfrWr      (sfrWr),
  .sfrBitOp   (sfrBitOp),
  .sfrAddr    (sfrAddr),
  .sfrWrData  (sfrWrData),
  .rdData     (rdData),
  .rdValid    (rdValid),
  .decodeErr  (decodeErr)
);

// File: tb/sim_banked_dmem.sv
`timescale 1ns/1ps
module sim_banked_dmem;

  logic       clk = 1'b0;
  logic       rstN;
  logic       reqValid;
  logic [2:0] accMode;
  logic [7:0] addr;
  logic [1:0] bankSel;
  logic       wrEn;
  logic [7:0] wrData;
  logic       xramEnable;
  logic [7:0] sfrRdData;
  logic       sfrReq, sfrWr, sfrBitOp;
  logic [7:0] sfrAddr, sfrWrData, rdData;
  logic       rdValid, decodeErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // SFR model: read value is a fixed function of the address.
  assign sfrRdData = sfrAddr ^ 8'h5A;

  banked_dmem u0 (.*);

  typedef struct packed {
    logic [2:0] mode;
    logic [7:0] a;
    logic [1:0] bank;
    logic       wr;
    logic [7:0] wd;
    logic       xen;
    logic [7:0] expRd;
    logic       expErr;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 8'h40, 2'd0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 4'd1},  // R1 storage cleared
    '{3'd0, 8'h10, 2'd0, 1'b1, 8'hA1, 1'b1, 8'h00, 1'b0, 4'd9},  // R9 write returns old
    '{3'd0, 8'h10, 2'd0, 1'b0, 8'h00, 1'b1, 8'hA1, 1'b0, 4'd2},  // R2 direct read
    '{3'd1, 8'h10, 2'd0, 1'b0, 8'h00, 1'b1, 8'hA1, 1'b0, 4'd2},  // R2 indirect same byte
    '{3'd1, 8'h90, 2'd0, 1'b1, 8'hB2, 1'b1, 8'h00, 1'b0, 4'd3},  // R3 indirect upper write
    '{3'd1, 8'h90, 2'd0, 1'b0, 8'h00, 1'b1, 8'hB2, 1'b0, 4'd3},  // R3 indirect upper read
    '{3'd0, 8'h90, 2'd0, 1'b0, 8'h00, 1'b1, 8'hCA, 1'b0, 4'd4},  // R4 direct upper -> SFR
    '{3'd0, 8'h90, 2'd0, 1'b1, 8'h77, 1'b1, 8'hCA, 1'b0, 4'd4},  // R4 SFR write
    '{3'd1, 8'h90, 2'd0, 1'b0, 8'h00, 1'b1, 8'hB2, 1'b0, 4'd4},  // R4 RAM untouched
    '{3'd2, 8'hFB, 2'd2, 1'b1, 8'hC3, 1'b1, 8'h00, 1'b0, 4'd5},  // R5 R3 bank2 -> 13h
    '{3'd0, 8'h13, 2'd0, 1'b0, 8'h00, 1'b1, 8'hC3, 1'b0, 4'd5},  // R5 check byte 13h
    '{3'd2, 8'h03, 2'd0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 4'd5},  // R5 bank0 R3 untouched
    '{3'd0, 8'h25, 2'd0, 1'b1, 8'hF0, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 preset byte 25h
    '{3'd3, 8'h2B, 2'd0, 1'b1, 8'h01, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 set bit3 of 25h
    '{3'd0, 8'h25, 2'd0, 1'b0, 8'h00, 1'b1, 8'hF8, 1'b0, 4'd6},  // R6 others kept
    '{3'd3, 8'h2C, 2'd0, 1'b1, 8'hFE, 1'b1, 8'h01, 1'b0, 4'd6},  // R6 clear bit4
    '{3'd0, 8'h25, 2'd0, 1'b0, 8'h00, 1'b1, 8'hE8, 1'b0, 4'd6},  // R6 others kept
    '{3'd3, 8'h2F, 2'd0, 1'b0, 8'h00, 1'b1, 8'h01, 1'b0, 4'd6},  // R6 bit read
    '{3'd4, 8'h10, 2'd0, 1'b1, 8'h5E, 1'b1, 8'h00, 1'b0, 4'd8},  // R8 expanded write
    '{3'd4, 8'h10, 2'd0, 1'b0, 8'h00, 1'b1, 8'h5E, 1'b0, 4'd8},  // R8 expanded read
    '{3'd0, 8'h10, 2'd0, 1'b0, 8'h00, 1'b1, 8'hA1, 1'b0, 4'd8},  // R8 no overlap
    '{3'd4, 8'h10, 2'd0, 1'b1, 8'h99, 1'b0, 8'h00, 1'b1, 4'd10}, // R10 disabled
    '{3'd4, 8'h10, 2'd0, 1'b0, 8'h00, 1'b1, 8'h5E, 1'b0, 4'd10}, // R10 unchanged
    '{3'd6, 8'h10, 2'd0, 1'b1, 8'h33, 1'b1, 8'h00, 1'b1, 4'd10}  // R10 bad mode
  };

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [7:0] a, input logic [1:0] b,
                       input logic w, input logic [7:0] d, input logic x);
    @(negedge clk);
    reqValid = 1'b1; accMode = m; addr = a; bankSel = b;
    wrEn = w; wrData = d; xramEnable = x;
  endtask

  task automatic finishReq();
    @(posedge clk);
    #1;
    reqValid = 1'b0; wrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; accMode = '0; addr = '0; bankSel = '0;
    wrEn = 1'b0; wrData = '0; xramEnable = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(rdData == 8'h00 && !rdValid && !decodeErr && !sfrReq, "R1 reset", rdData, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check(rdData == 8'h00 && !rdValid && !decodeErr, "R1 after reset", rdData, 0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].mode, VECS[i].a, VECS[i].bank, VECS[i].wr, VECS[i].wd, VECS[i].xen);
      finishReq();
      checks++;
      if (rdData !== VECS[i].expRd || decodeErr !== VECS[i].expErr || rdValid !== 1'b1) begin
        errors++;
        $display("FAIL R%0d vec %0d actual=%0h/err%0b expected=%0h/err%0b",
                 VECS[i].req, i, rdData, decodeErr, VECS[i].expRd, VECS[i].expErr);
      end
    end

    // R4: SFR port signals in the request cycle of a direct upper write.
    drive(3'd0, 8'hA7, 2'd0, 1'b1, 8'h3C, 1'b1);
    #1;
    check(sfrReq && sfrWr && !sfrBitOp && sfrAddr == 8'hA7 && sfrWrData == 8'h3C,
          "R4 port", {sfrReq, sfrWr, sfrBitOp, sfrAddr, sfrWrData}, {3'b110, 8'hA7, 8'h3C});
    finishReq();
    check(rdData == (8'hA7 ^ 8'h5A), "R4 sfr read", rdData, 8'hA7 ^ 8'h5A);

    // R7: upper bit address forwarded as a bit access.
    drive(3'd3, 8'h85, 2'd0, 1'b1, 8'hFF, 1'b1);
    #1;
    check(sfrReq && sfrWr && sfrBitOp && sfrAddr == 8'h85 && sfrWrData == 8'h01,
          "R7 port", {sfrReq, sfrWr, sfrBitOp, sfrAddr, sfrWrData}, {3'b111, 8'h85, 8'h01});
    finishReq();
    check(rdData == 8'h01, "R7 sfr bit read", rdData, 8'h01);

    // R3: indirect upper access leaves the SFR port idle.
    drive(3'd1, 8'hA7, 2'd0, 1'b0, 8'h00, 1'b1);
    #1;
    check(!sfrReq, "R3 no sfr", sfrReq, 0);
    finishReq();
    check(rdData == 8'h00, "R3 upper byte untouched by R4 write", rdData, 0);

    // R11: wrEn without reqValid does nothing.
    @(negedge clk);
    reqValid = 1'b0; accMode = 3'd0; addr = 8'h10; wrEn = 1'b1; wrData = 8'hEE;
    #1;
    check(!sfrReq && !sfrWr, "R11 port idle", {sfrReq, sfrWr}, 0);
    repeat (3) @(posedge clk);
    #1;
    check(!rdValid, "R11 no answer", rdValid, 0);
    drive(3'd0, 8'h10, 2'd0, 1'b0, 8'h00, 1'b1);
    finishReq();
    check(rdData == 8'hA1, "R11 byte kept", rdData, 8'hA1);

    // R9: answer one cycle only, rdValid drops the cycle after.
    @(posedge clk); #1;
    check(!rdValid, "R9 single answer", rdValid, 0);

    // R10: refused expanded write leaves the SFR port quiet.
    drive(3'd4, 8'hF0, 2'd0, 1'b1, 8'h11, 1'b0);
    #1;
    check(!sfrReq && !sfrWr, "R10 port quiet", {sfrReq, sfrWr}, 0);
    finishReq();
    check(decodeErr && rdData == 8'h00, "R10 error", {decodeErr, rdData}, 9'h100);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule